// File: doc/BRIEF.md
# UART Register Bank with Interrupt Combiner

This block is the software-visible register bank of a serial port. A processor reaches it through a simple 32-bit word access port covering a 4 KiB window. The bank holds the configuration fields that the rest of the port uses: baud divisors, frame format, control, FIFO trigger levels, DMA enables and the infrared low-power divisor. It forwards data-register traffic to the FIFO logic as one-cycle strobes and keeps a sticky receive-error register. A fixed identification byte sequence sits at the top of the window.

Hardware events from the FIFO, serializer and modem-line logic set bits in an eleven-bit raw interrupt status. Software masks that status, reads it in raw and masked form, and clears it by writing ones. Six interrupt outputs are derived from the masked status: one combined line and five per-source lines. The FIFO storage, the serializer and the DMA engine sit outside this block.

Top module: `uart_regbank`

## Requirements
- R1: An access is one cycle with `acc_valid` high. A read returns its word on `acc_rdata` in the cycle after the access, and `acc_rdata` holds that word until the next read. An offset whose low two bits are not zero, or that maps to no register, reads as zero and ignores writes.
- R2: The registers sit at these word offsets: data 0x000, receive status 0x004, flags 0x018, infrared divisor 0x020, integer divisor 0x024, fractional divisor 0x028, line control 0x02C, control 0x030, FIFO level 0x034, mask 0x038, raw status 0x03C, masked status 0x040, clear 0x044, DMA control 0x048. The writable fields keep the low 16, 6, 8, 8, 16, 6, 11 and 3 bits (integer divisor, fractional divisor, infrared divisor, line control, control, FIFO level, mask, DMA control), read back zero-extended, and drive the matching configuration outputs.
- R3: While `rst_n` is low at a clock edge, every register clears except FIFO level, which becomes 0x12, and control, which becomes 0x0300. `fifo_flush` is high in the cycle after each such edge.
- R4: Masked status reads as raw status AND mask. A write to the mask changes the interrupt outputs in the next cycle.
- R5: Writing the clear register clears every raw status bit where the written word has a 1. An event that sets the same bit in the same cycle wins. The clear register reads as zero.
- R6: The flags register reads `flag_in`. Writes to the flags, raw status and masked status registers change nothing.
- R7: Receive status holds four sticky bits set by `rxerr_set`. Any write to it clears it, and a set in the same cycle wins.
- R8: Raw status positions: ring 0, clear-to-send 1, carrier 2, data-set-ready 3, receive 4, transmit 5, receive timeout 6, framing 7, parity 8, break 9, overrun 10. `irq_rx`, `irq_tx` and `irq_rt` follow masked bits 4, 5 and 6. `irq_ms` is the OR of masked bits 0 to 3, `irq_err` the OR of masked bits 7 to 10, and `irq_any` the OR of all masked bits.
- R9: Word reads at 0xFE0, 0xFE4 and so on up to 0xFFC return one identification byte each: 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: A data-register write raises `tx_push` in the same cycle with `tx_byte` equal to the low byte written. It also sets the transmit raw status bit (bit 5) from the next cycle.
- R11: A data-register read raises `rx_pop` in the same cycle and returns `rx_word_in` zero-extended.
- R12: A line-control write that flips bit 4 (FIFO enable) raises `fifo_flush` for the next cycle. A write that leaves bit 4 unchanged does not.
- R13: A bit high on `evt_set` at a clock edge sets the matching raw status bit. The bit stays set until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte offset within the window |
| acc_wdata | input | 32 | Write word |
| acc_rdata | output | 32 | Read word, valid the cycle after a read |
| flag_in | input | 9 | Live flag word shown by the flags register |
| rx_word_in | input | 12 | Head of the receive FIFO (data plus error bits) |
| rx_pop | output | 1 | Data-register read strobe |
| tx_push | output | 1 | Data-register write strobe |
| tx_byte | output | 8 | Byte to transmit |
| evt_set | input | 11 | Raw status set pulses |
| rxerr_set | input | 4 | Receive status set pulses |
| baud_int | output | 16 | Integer baud divisor |
| baud_frac | output | 6 | Fractional baud divisor |
| irda_div | output | 8 | Infrared low-power divisor |
| line_cfg | output | 8 | Line control field |
| ctrl_cfg | output | 16 | Control field |
| level_cfg | output | 6 | FIFO trigger level field |
| dma_cfg | output | 3 | DMA enable field |
| fifo_flush | output | 1 | FIFO flush request |
| irq_any | output | 1 | Combined interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rt | output | 1 | Receive-timeout interrupt |
| irq_ms | output | 1 | Modem-status interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
Three latencies matter here. The strobes `rx_pop`, `tx_push` and `tx_byte` follow the access in the same cycle. Register contents, `fifo_flush` and the six interrupt lines change one edge after the access or event that causes them. Read data appears one edge after the read and shows the state from before that edge. The bench drives stimulus on the falling edge and checks the strobes a nanosecond later. It compares the registered outputs with a behavioural model on every falling edge, so every comparison falls exactly one edge after its cause.

// File: rtl/uart_rb_pkg.sv
// Shared constants for the UART register bank: word offsets, select
// indices, raw status bit positions, interrupt line groups and the
// identification byte sequence. Assumes a 12-bit byte address space.
package uart_rb_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int STAT_W = 11;
    localparam int RSR_W  = 4;
    localparam int NLINES = 5;

    // word offsets (byte offset >> 2)
    localparam logic [9:0] W_DR   = 10'd0;
    localparam logic [9:0] W_RSR  = 10'd1;
    localparam logic [9:0] W_FR   = 10'd6;
    localparam logic [9:0] W_ILPR = 10'd8;
    localparam logic [9:0] W_IBRD = 10'd9;
    localparam logic [9:0] W_FBRD = 10'd10;
    localparam logic [9:0] W_LCR  = 10'd11;
    localparam logic [9:0] W_CR   = 10'd12;
    localparam logic [9:0] W_IFLS = 10'd13;
    localparam logic [9:0] W_IMSC = 10'd14;
    localparam logic [9:0] W_RIS  = 10'd15;
    localparam logic [9:0] W_MIS  = 10'd16;
    localparam logic [9:0] W_ICR  = 10'd17;
    localparam logic [9:0] W_DMA  = 10'd18;
    localparam logic [6:0] ID_PAGE = 7'h7F;   // byte offsets 0xFE0..0xFFF

    // one-hot select indices
    localparam int S_DR   = 0;
    localparam int S_RSR  = 1;
    localparam int S_FR   = 2;
    localparam int S_ILPR = 3;
    localparam int S_IBRD = 4;
    localparam int S_FBRD = 5;
    localparam int S_LCR  = 6;
    localparam int S_CR   = 7;
    localparam int S_IFLS = 8;
    localparam int S_IMSC = 9;
    localparam int S_RIS  = 10;
    localparam int S_MIS  = 11;
    localparam int S_ICR  = 12;
    localparam int S_DMA  = 13;
    localparam int S_ID   = 14;
    localparam int NSEL   = 15;

    // raw status bit positions
    localparam int B_RI  = 0;
    localparam int B_CTS = 1;
    localparam int B_DCD = 2;
    localparam int B_DSR = 3;
    localparam int B_RX  = 4;
    localparam int B_TX  = 5;
    localparam int B_RT  = 6;
    localparam int B_FE  = 7;
    localparam int B_PE  = 8;
    localparam int B_BE  = 9;
    localparam int B_OE  = 10;

    localparam int LCR_FEN_BIT = 4;

    // Bits of the raw status that feed per-source line i (rx, tx, rt, ms, err).
    function automatic logic [STAT_W-1:0] line_mask(input int i);
        logic [STAT_W-1:0] m;
        m = '0;
        case (i)
            0: m[B_RX] = 1'b1;
            1: m[B_TX] = 1'b1;
            2: m[B_RT] = 1'b1;
            3: begin
                m[B_RI] = 1'b1; m[B_CTS] = 1'b1; m[B_DCD] = 1'b1; m[B_DSR] = 1'b1;
            end
            default: begin
                m[B_FE] = 1'b1; m[B_PE] = 1'b1; m[B_BE] = 1'b1; m[B_OE] = 1'b1;
            end
        endcase
        return m;
    endfunction

    // Identification byte for slot i of the top page.
    function automatic logic [7:0] id_byte(input logic [2:0] i);
        case (i)
            3'd0:    return 8'h11;
            3'd1:    return 8'h10;
            3'd2:    return 8'h14;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/uart_rb_decode.sv
// Address decoder: turns a byte offset into a one-hot register select.
// Assumes word accesses only; any offset with nonzero low bits, or one
// that names no register, yields an all-zero select.
module uart_rb_decode
    import uart_rb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [NSEL-1:0]   sel,
    output logic [2:0]        id_idx
);

    assign id_idx = addr[4:2];

    // Map the word offset onto exactly one select bit, or none.
    always_comb begin
        sel = '0;
        if (addr[1:0] == 2'b00) begin
            case (addr[ADDR_W-1:2])
                W_DR:    sel[S_DR]   = 1'b1;
                W_RSR:   sel[S_RSR]  = 1'b1;
                W_FR:    sel[S_FR]   = 1'b1;
                W_ILPR:  sel[S_ILPR] = 1'b1;
                W_IBRD:  sel[S_IBRD] = 1'b1;
                W_FBRD:  sel[S_FBRD] = 1'b1;
                W_LCR:   sel[S_LCR]  = 1'b1;
                W_CR:    sel[S_CR]   = 1'b1;
                W_IFLS:  sel[S_IFLS] = 1'b1;
                W_IMSC:  sel[S_IMSC] = 1'b1;
                W_RIS:   sel[S_RIS]  = 1'b1;
                W_MIS:   sel[S_MIS]  = 1'b1;
                W_ICR:   sel[S_ICR]  = 1'b1;
                W_DMA:   sel[S_DMA]  = 1'b1;
                default: sel[S_ID]   = (addr[ADDR_W-1:5] == ID_PAGE);
            endcase
        end
    end

endmodule

// File: rtl/uart_rb_field.sv
// One writable configuration field with a synchronous reset value.
// Assumes the caller has already qualified the write enable.
module uart_rb_field #(
    parameter int           W   = 8,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Load on write, return to the reset value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST;
        else if (we) q <= d;
    end

endmodule

// File: rtl/uart_rb_cfg.sv
// Configuration fields of the register bank (divisors, line control,
// control, FIFO level, DMA enables) and the FIFO flush request.
// Assumes sel is one-hot or zero and wr is already qualified by valid.
module uart_rb_cfg
    import uart_rb_pkg::*;
#(
    parameter int IBRD_W = 16,
    parameter int FBRD_W = 6,
    parameter int ILPR_W = 8,
    parameter int LCR_W  = 8,
    parameter int CR_W   = 16,
    parameter int IFLS_W = 6,
    parameter int DMA_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [NSEL-1:0]   sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [IBRD_W-1:0] ibrd,
    output logic [FBRD_W-1:0] fbrd,
    output logic [ILPR_W-1:0] ilpr,
    output logic [LCR_W-1:0]  lcr,
    output logic [CR_W-1:0]   cr,
    output logic [IFLS_W-1:0] ifls,
    output logic [DMA_W-1:0]  dma,
    output logic              flush
);

    localparam logic [IFLS_W-1:0] IFLS_RST = IFLS_W'(6'h12);
    localparam logic [CR_W-1:0]   CR_RST   = CR_W'(16'h0300);

    uart_rb_field #(.W(IBRD_W)) u_ibrd (.clk(clk), .rst_n(rst_n),
        .we(wr && sel[S_IBRD]), .d(wdata[IBRD_W-1:0]), .q(ibrd));
    uart_rb_field #(.W(FBRD_W)) u_fbrd (.clk(clk), .rst_n(rst_n),
        .we(wr && sel[S_FBRD]), .d(wdata[FBRD_W-1:0]), .q(fbrd));
    uart_rb_field #(.W(ILPR_W)) u_ilpr (.clk(clk), .rst_n(rst_n),
        .we(wr && sel[S_ILPR]), .d(wdata[ILPR_W-1:0]), .q(ilpr));
    uart_rb_field #(.W(LCR_W)) u_lcr (.clk(clk), .rst_n(rst_n),
        .we(wr && sel[S_LCR]), .d(wdata[LCR_W-1:0]), .q(lcr));
    uart_rb_field #(.W(CR_W), .RST(CR_RST)) u_cr (.clk(clk), .rst_n(rst_n),
        .we(wr && sel[S_CR]), .d(wdata[CR_W-1:0]), .q(cr));
    uart_rb_field #(.W(IFLS_W), .RST(IFLS_RST)) u_ifls (.clk(clk), .rst_n(rst_n),
        .we(wr && sel[S_IFLS]), .d(wdata[IFLS_W-1:0]), .q(ifls));
    uart_rb_field #(.W(DMA_W)) u_dma (.clk(clk), .rst_n(rst_n),
        .we(wr && sel[S_DMA]), .d(wdata[DMA_W-1:0]), .q(dma));

    // Request a flush after reset and whenever the FIFO enable bit flips.
    always_ff @(posedge clk) begin
        if (!rst_n) flush <= 1'b1;
        else        flush <= wr && sel[S_LCR] &&
                             (wdata[LCR_FEN_BIT] != lcr[LCR_FEN_BIT]);
    end

endmodule

// File: rtl/uart_rb_irq.sv
// Interrupt core: raw status with set-wins write-1-to-clear, mask,
// sticky receive status, and the per-source and combined lines.
// Assumes evt_set and rxerr_set are single-cycle level samples.
module uart_rb_irq
    import uart_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [NSEL-1:0]   sel,
    input  logic [STAT_W-1:0] wbits,
    input  logic [STAT_W-1:0] evt_set,
    input  logic [RSR_W-1:0]  rxerr_set,
    output logic [STAT_W-1:0] raw,
    output logic [STAT_W-1:0] mask,
    output logic [RSR_W-1:0]  rsr,
    output logic              irq_all,
    output logic [NLINES-1:0] irq_line
);

    logic [STAT_W-1:0] clr_bits;
    logic [STAT_W-1:0] hw_set;
    logic [STAT_W-1:0] masked;

    // Gather the clear word and the set sources for this cycle.
    always_comb begin
        clr_bits = (wr && sel[S_ICR]) ? wbits : '0;
        hw_set   = evt_set;
        if (wr && sel[S_DR]) hw_set[B_TX] = 1'b1;
    end

    // Raw status: clear requested bits, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= (raw & ~clr_bits) | hw_set;
    end

    // Interrupt mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)                  mask <= '0;
        else if (wr && sel[S_IMSC])  mask <= wbits;
    end

    // Sticky receive status; any write clears, a new error still lands.
    always_ff @(posedge clk) begin
        if (!rst_n) rsr <= '0;
        else        rsr <= ((wr && sel[S_RSR]) ? '0 : rsr) | rxerr_set;
    end

    assign masked  = raw & mask;
    assign irq_all = |masked;

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        localparam logic [STAT_W-1:0] LM = line_mask(g);
        assign irq_line[g] = |(masked & LM);
    end

endmodule

// File: rtl/uart_regbank.sv
// UART register bank top: decodes word accesses, routes writes to the
// configuration and interrupt cores, registers read data and issues
// data-register strobes. Assumes one access per valid cycle.
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int IBRD_W = 16,
    parameter int FBRD_W = 6,
    parameter int ILPR_W = 8,
    parameter int LCR_W  = 8,
    parameter int CR_W   = 16,
    parameter int IFLS_W = 6,
    parameter int DMA_W  = 3,
    parameter int FLAG_W = 9,
    parameter int RXW    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [11:0]       acc_addr,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       acc_rdata,
    input  logic [FLAG_W-1:0] flag_in,
    input  logic [RXW-1:0]    rx_word_in,
    output logic              rx_pop,
    output logic              tx_push,
    output logic [7:0]        tx_byte,
    input  logic [10:0]       evt_set,
    input  logic [3:0]        rxerr_set,
    output logic [IBRD_W-1:0] baud_int,
    output logic [FBRD_W-1:0] baud_frac,
    output logic [ILPR_W-1:0] irda_div,
    output logic [LCR_W-1:0]  line_cfg,
    output logic [CR_W-1:0]   ctrl_cfg,
    output logic [IFLS_W-1:0] level_cfg,
    output logic [DMA_W-1:0]  dma_cfg,
    output logic              fifo_flush,
    output logic              irq_any,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_rt,
    output logic              irq_ms,
    output logic              irq_err
);

    logic [NSEL-1:0]   sel;
    logic [2:0]        id_idx;
    logic              wr, rd;
    logic [STAT_W-1:0] raw_q, mask_q;
    logic [RSR_W-1:0]  rsr_q;
    logic [NLINES-1:0] lines;
    logic [DATA_W-1:0] rd_val;

    assign wr = acc_valid && acc_write;
    assign rd = acc_valid && !acc_write;

    uart_rb_decode u_dec (.addr(acc_addr), .sel(sel), .id_idx(id_idx));

    uart_rb_cfg #(
        .IBRD_W(IBRD_W), .FBRD_W(FBRD_W), .ILPR_W(ILPR_W), .LCR_W(LCR_W),
        .CR_W(CR_W), .IFLS_W(IFLS_W), .DMA_W(DMA_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(wr), .sel(sel), .wdata(acc_wdata),
        .ibrd(baud_int), .fbrd(baud_frac), .ilpr(irda_div), .lcr(line_cfg),
        .cr(ctrl_cfg), .ifls(level_cfg), .dma(dma_cfg), .flush(fifo_flush)
    );

    uart_rb_irq u_irq (
        .clk(clk), .rst_n(rst_n), .wr(wr), .sel(sel),
        .wbits(acc_wdata[STAT_W-1:0]), .evt_set(evt_set), .rxerr_set(rxerr_set),
        .raw(raw_q), .mask(mask_q), .rsr(rsr_q),
        .irq_all(irq_any), .irq_line(lines)
    );

    assign irq_rx  = lines[0];
    assign irq_tx  = lines[1];
    assign irq_rt  = lines[2];
    assign irq_ms  = lines[3];
    assign irq_err = lines[4];

    // Data-register strobes follow the access in the same cycle.
    assign rx_pop  = rd && sel[S_DR];
    assign tx_push = wr && sel[S_DR];
    assign tx_byte = acc_wdata[7:0];

    // Readback multiplexer over the one-hot select.
    always_comb begin
        rd_val = '0;
        if (sel[S_DR])   rd_val = DATA_W'(rx_word_in);
        if (sel[S_RSR])  rd_val = DATA_W'(rsr_q);
        if (sel[S_FR])   rd_val = DATA_W'(flag_in);
        if (sel[S_ILPR]) rd_val = DATA_W'(irda_div);
        if (sel[S_IBRD]) rd_val = DATA_W'(baud_int);
        if (sel[S_FBRD]) rd_val = DATA_W'(baud_frac);
        if (sel[S_LCR])  rd_val = DATA_W'(line_cfg);
        if (sel[S_CR])   rd_val = DATA_W'(ctrl_cfg);
        if (sel[S_IFLS]) rd_val = DATA_W'(level_cfg);
        if (sel[S_IMSC]) rd_val = DATA_W'(mask_q);
        if (sel[S_RIS])  rd_val = DATA_W'(raw_q);
        if (sel[S_MIS])  rd_val = DATA_W'(raw_q & mask_q);
        if (sel[S_DMA])  rd_val = DATA_W'(dma_cfg);
        if (sel[S_ID])   rd_val = DATA_W'(id_byte(id_idx));
    end

    // Capture read data one edge after the read; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  acc_rdata <= '0;
        else if (rd) acc_rdata <= rd_val;
    end

endmodule

// File: rtl/uart_regbank_chk.sv
// Checker for the UART register bank, bound to the top module. It
// observes ports plus the decoder select and interrupt-core state.
module uart_regbank_chk
    import uart_rb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [31:0]       acc_wdata,
    input logic [31:0]       acc_rdata,
    input logic [10:0]       evt_set,
    input logic [3:0]        rxerr_set,
    input logic [NSEL-1:0]   sel,
    input logic [STAT_W-1:0] raw_q,
    input logic [STAT_W-1:0] mask_q,
    input logic [RSR_W-1:0]  rsr_q,
    input logic              irq_any,
    input logic              irq_rx,
    input logic              irq_tx,
    input logic              irq_rt,
    input logic              irq_ms,
    input logic              irq_err
);

    logic wr, rd;
    assign wr = acc_valid && acc_write;
    assign rd = acc_valid && !acc_write;

    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel[S_IMSC]) |=> mask_q == $past(acc_wdata[STAT_W-1:0]));

    assert_mis_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel[S_MIS]) |=> acc_rdata == 32'($past(raw_q & mask_q)));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel[S_ICR] && evt_set == '0) |=>
        (raw_q & $past(acc_wdata[STAT_W-1:0])) == '0);

    assert_icr_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel[S_ICR]) |=> acc_rdata == 32'd0);

    assert_ro_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (sel[S_FR] || sel[S_RIS] || sel[S_MIS]) && evt_set == '0) |=>
        (raw_q == $past(raw_q) && mask_q == $past(mask_q)));

    assert_rsr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel[S_RSR] && rxerr_set == '0) |=> rsr_q == '0);

    assert_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == (irq_rx || irq_tx || irq_rt || irq_ms || irq_err));

    assert_tx_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel[S_DR]) |=> raw_q[B_TX]);

    assert_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> (raw_q & $past(evt_set)) == $past(evt_set));

endmodule

bind uart_regbank uart_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .evt_set(evt_set),
    .rxerr_set(rxerr_set), .sel(sel), .raw_q(raw_q), .mask_q(mask_q),
    .rsr_q(rsr_q), .irq_any(irq_any), .irq_rx(irq_rx), .irq_tx(irq_tx),
    .irq_rt(irq_rt), .irq_ms(irq_ms), .irq_err(irq_err)
);

// File: tb/uart_regbank_test.sv
// Bench for uart_regbank: behavioural reference model compared every
// falling edge, plus directed checks against literal expected values.
module uart_regbank_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid, acc_write;
    logic [11:0] acc_addr;
    logic [31:0] acc_wdata, acc_rdata;
    logic [8:0]  flag_in;
    logic [11:0] rx_word_in;
    logic        rx_pop, tx_push;
    logic [7:0]  tx_byte;
    logic [10:0] evt_set;
    logic [3:0]  rxerr_set;
    logic [15:0] baud_int;
    logic [5:0]  baud_frac;
    logic [7:0]  irda_div, line_cfg;
    logic [15:0] ctrl_cfg;
    logic [5:0]  level_cfg;
    logic [2:0]  dma_cfg;
    logic        fifo_flush;
    logic        irq_any, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;

    always #10 clk = ~clk;

    uart_regbank uut (.*);

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [10:0] m_raw, m_mask;
    logic [3:0]  m_rsr;
    logic [15:0] m_ibrd, m_cr;
    logic [5:0]  m_fbrd, m_ifls;
    logic [7:0]  m_ilpr, m_lcr;
    logic [2:0]  m_dma;
    logic [31:0] m_rdata;
    logic        m_flush;
    byte unsigned id_tab [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    function automatic logic [31:0] m_read(input logic [11:0] a);
        if (a[1:0] != 2'b00) return 32'd0;
        if (a >= 12'hFE0) return 32'(id_tab[(a - 12'hFE0) >> 2]);
        case (a)
            12'h000: return 32'(rx_word_in);
            12'h004: return 32'(m_rsr);
            12'h018: return 32'(flag_in);
            12'h020: return 32'(m_ilpr);
            12'h024: return 32'(m_ibrd);
            12'h028: return 32'(m_fbrd);
            12'h02C: return 32'(m_lcr);
            12'h030: return 32'(m_cr);
            12'h034: return 32'(m_ifls);
            12'h038: return 32'(m_mask);
            12'h03C: return 32'(m_raw);
            12'h040: return 32'(m_raw & m_mask);
            12'h048: return 32'(m_dma);
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [10:0] clr, set;
        logic        rsr_wr;
        clr = '0; set = evt_set; rsr_wr = 1'b0;
        if (!rst_n) begin
            m_raw = 0; m_mask = 0; m_rsr = 0; m_ibrd = 0; m_fbrd = 0; m_ilpr = 0;
            m_lcr = 0; m_cr = 16'h0300; m_ifls = 6'h12; m_dma = 0; m_rdata = 0;
            m_flush = 1'b1;
        end else begin
            m_flush = 1'b0;
            if (acc_valid && !acc_write) m_rdata = m_read(acc_addr);
            if (acc_valid && acc_write) begin
                case (acc_addr)
                    12'h000: set[5] = 1'b1;
                    12'h004: rsr_wr = 1'b1;
                    12'h020: m_ilpr = acc_wdata[7:0];
                    12'h024: m_ibrd = acc_wdata[15:0];
                    12'h028: m_fbrd = acc_wdata[5:0];
                    12'h02C: begin
                        m_flush = (acc_wdata[4] != m_lcr[4]);
                        m_lcr = acc_wdata[7:0];
                    end
                    12'h030: m_cr = acc_wdata[15:0];
                    12'h034: m_ifls = acc_wdata[5:0];
                    12'h038: m_mask = acc_wdata[10:0];
                    12'h044: clr = acc_wdata[10:0];
                    12'h048: m_dma = acc_wdata[2:0];
                    default: ;
                endcase
            end
            m_raw = (m_raw & ~clr) | set;
            m_rsr = (rsr_wr ? 4'd0 : m_rsr) | rxerr_set;
        end
    end

    // Compare registered outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            logic [10:0] mm;
            mm = m_raw & m_mask;
            check("R1 model rdata", 64'(acc_rdata), 64'(m_rdata));
            check("R8 model irq lines",
                  64'({irq_any, irq_rx, irq_tx, irq_rt, irq_ms, irq_err}),
                  64'({|mm, mm[4], mm[5], mm[6], |mm[3:0], |mm[10:7]}));
            check("R2 model config",
                  64'({baud_int, baud_frac, irda_div, line_cfg, ctrl_cfg, level_cfg, dma_cfg}),
                  64'({m_ibrd, m_fbrd, m_ilpr, m_lcr, m_cr, m_ifls, m_dma}));
            check("R12 model flush", 64'(fifo_flush), 64'(m_flush));
        end
    end

    // ---------------- stimulus helpers (called at a falling edge) ----------
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0;
        check(tag, 64'(acc_rdata), 64'(e));
    endtask

    task automatic pulse_evt(input logic [10:0] e);
        evt_set = e;
        @(negedge clk);
        evt_set = '0;
    endtask

    function automatic logic [63:0] lines();
        return 64'({irq_any, irq_rx, irq_tx, irq_rt, irq_ms, irq_err});
    endfunction

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; acc_valid = 0; acc_write = 0; acc_addr = 0; acc_wdata = 0;
        flag_in = 9'h090; rx_word_in = 12'h000; evt_set = 0; rxerr_set = 0;
        repeat (3) @(negedge clk);
        cmp_on = 1'b1;
        check("R3 flush during reset", 64'(fifo_flush), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 flush ends", 64'(fifo_flush), 64'd0);
        check("R3 irq lines idle", lines(), 64'd0);

        // R3 reset values
        rd(12'h034, 32'h12, "R3 level reset");
        rd(12'h030, 32'h300, "R3 control reset");
        rd(12'h024, 32'h0, "R3 divisor reset");
        rd(12'h03C, 32'h0, "R3 raw reset");
        rd(12'h018, 32'h090, "R6 flags read");

        // R9 identification bytes
        for (int k = 0; k < 8; k++)
            rd(12'hFE0 + 12'(4 * k), 32'(id_tab[k]), "R9 id byte");

        // R2 field widths
        wr(12'h024, 32'hFFFF_FFFF); rd(12'h024, 32'h0000_FFFF, "R2 integer divisor width");
        wr(12'h028, 32'hFFFF_FFFF); rd(12'h028, 32'h3F, "R2 fractional divisor width");
        wr(12'h020, 32'h1FF);       rd(12'h020, 32'hFF, "R2 infrared divisor width");
        wr(12'h030, 32'h1234_5678); rd(12'h030, 32'h5678, "R2 control width");
        wr(12'h034, 32'hFF);        rd(12'h034, 32'h3F, "R2 level width");
        wr(12'h048, 32'hF);         rd(12'h048, 32'h7, "R2 dma width");
        check("R2 divisor output", 64'(baud_int), 64'hFFFF);

        // R12 flush on FIFO-enable flip
        wr(12'h02C, 32'h70);
        check("R12 flush on flip", 64'(fifo_flush), 64'd1);
        wr(12'h02C, 32'h71);
        check("R12 no flush without flip", 64'(fifo_flush), 64'd0);
        rd(12'h02C, 32'h71, "R2 line control readback");

        // R1 unaligned and unmapped offsets
        rd(12'h025, 32'h0, "R1 unaligned read");
        rd(12'h04C, 32'h0, "R1 unmapped read");
        rd(12'h800, 32'h0, "R1 unmapped mid-window read");
        wr(12'h04C, 32'hFFFF_FFFF);
        wr(12'h026, 32'h0);
        rd(12'h024, 32'h0000_FFFF, "R1 stray writes ignored");
        check("R1 rdata held", 64'(acc_rdata), 64'h0000_FFFF);

        // R10 transmit strobe and status
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 12'h000; acc_wdata = 32'h1A5;
        #1;
        check("R10 tx_push strobe", 64'(tx_push), 64'd1);
        check("R10 tx_byte", 64'(tx_byte), 64'hA5);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        #1;
        check("R10 tx_push drops", 64'(tx_push), 64'd0);
        check("R4 masked off keeps lines low", lines(), 64'd0);
        rd(12'h03C, 32'h20, "R10 transmit raw bit");

        // R4 mask
        wr(12'h038, 32'h7FF);
        check("R4 tx line after mask", lines(), 64'b101000);
        rd(12'h040, 32'h20, "R4 masked status");

        // R6 read-only writes ignored
        wr(12'h03C, 32'hFFFF_FFFF);
        wr(12'h040, 32'hFFFF_FFFF);
        wr(12'h018, 32'hFFFF_FFFF);
        rd(12'h03C, 32'h20, "R6 raw unchanged");
        rd(12'h038, 32'h7FF, "R6 mask unchanged");
        flag_in = 9'h1A5;
        rd(12'h018, 32'h1A5, "R6 flags follow input");

        // R5 clear
        wr(12'h044, 32'h20);
        check("R5 lines after clear", lines(), 64'd0);
        rd(12'h03C, 32'h0, "R5 raw cleared");
        rd(12'h044, 32'h0, "R5 clear reads zero");

        // R8 / R13 line grouping
        pulse_evt(11'h001); check("R8 ring -> ms line", lines(), 64'b100010);
        wr(12'h044, 32'h7FF);
        pulse_evt(11'h200); check("R8 break -> err line", lines(), 64'b100001);
        wr(12'h044, 32'h7FF);
        pulse_evt(11'h040); check("R8 timeout -> rt line", lines(), 64'b100100);
        wr(12'h044, 32'h7FF);
        pulse_evt(11'h010); check("R8 receive -> rx line", lines(), 64'b110000);
        repeat (2) @(negedge clk);
        check("R13 sticky raw bit", lines(), 64'b110000);
        pulse_evt(11'h408);
        rd(12'h03C, 32'h418, "R13 raw accumulates");

        // R4 partial mask
        wr(12'h038, 32'h010);
        check("R4 only rx line", lines(), 64'b110000);
        rd(12'h040, 32'h010, "R4 partial masked status");

        // R5 set wins over clear in the same cycle
        evt_set = 11'h010;
        wr(12'h044, 32'h418);
        evt_set = '0;
        rd(12'h03C, 32'h010, "R5 set wins over clear");

        // R7 receive status
        rxerr_set = 4'b0101; @(negedge clk); rxerr_set = 4'b0000;
        rd(12'h004, 32'h5, "R7 sticky errors");
        wr(12'h004, 32'h0);
        rd(12'h004, 32'h0, "R7 write clears");

        // R11 receive pop
        rx_word_in = 12'hABC;
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 12'h000;
        #1;
        check("R11 rx_pop strobe", 64'(rx_pop), 64'd1);
        @(negedge clk);
        acc_valid = 1'b0;
        check("R11 data read", 64'(acc_rdata), 64'hABC);

        // R3 reset mid-run
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        check("R3 flush after reset", 64'(fifo_flush), 64'd1);
        @(negedge clk);
        rd(12'h038, 32'h0, "R3 mask cleared");
        rd(12'h024, 32'h0, "R3 divisor cleared");
        rd(12'h034, 32'h12, "R3 level restored");
        check("R3 lines cleared", lines(), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule